// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This block watches the address bus of an 8-bit controller with a 16-bit address space and raises a break request when a valid bus cycle hits a programmed address. Software programs the target address through two byte-wide registers, high byte and low byte. It arms the comparator with an enable flag in a control byte. When the comparator fires, an active flag is latched and the interrupt request line stays high until software clears that flag. Software can also raise a break with no address hit by writing the active flag to 1.

The activity state machine has two states. `ST_IDLE` means no break is pending. `ST_ACTIVE` means a break is pending and the request is driven. It has three transitions:

- `T_HIT`: an enabled, valid address hit, from either state, ending in `ST_ACTIVE`.
- `T_FORCE`: a software write of 1 to the active flag, ending in `ST_ACTIVE`.
- `T_CLEAR`: a software write of 0 to the active flag in a cycle with no hit, from `ST_ACTIVE` to `ST_IDLE`.

In any other cycle the state is held.

A break that occurs while the core is in stop or wait mode also sets a sticky low-power break flag. Software reads this flag to learn that the core woke through a break. While the core is in stop mode, a pending break drives a stop-exit output.

Top module: `brkpt_unit`

## Requirements
- R1: After reset every register reads 0x00, `brk_irq` is 0 and `stop_exit` is 0.
- R2: Offset 0 is the control byte: bit 7 is the enable flag and bit 6 is the active flag. Bits 5..0 always read 0 whatever was written. Offset 3 is the status byte: only bit 1 (the low-power break flag) can read 1.
- R3: While enabled, a cycle with `bus_vld`=1 and `bus_addr` equal to {high byte, low byte} sets the active flag at that clock edge (`T_HIT`), and `brk_irq` is 1 from then on. An address that differs in any single bit does not set it.
- R4: While the enable flag is 0, an address hit has no effect on the active flag or on `brk_irq`.
- R5: A cycle with `bus_vld`=0 never causes a hit, whatever the address.
- R6: Writing the control byte with bit 6 = 1 sets the active flag and raises `brk_irq` at that edge, with no address hit (`T_FORCE`).
- R7: Writing the control byte with bit 6 = 0 clears the active flag (`T_CLEAR`), and `brk_irq` is 0 after that edge.
- R8: When a hit and a write of 0 to bit 6 fall in the same cycle, the active flag ends at 1.
- R9: Bit 7 of the control byte takes the written value, so writing 0 there disarms the comparator.
- R10: Offset 1 holds the high address byte and offset 2 holds the low address byte. Each reads back what was last written to it.
- R11: A break event (hit or forced) while `stop_mode` or `wait_mode` is 1 sets status bit 1. The flag stays set after the active flag is cleared. A break with both mode inputs at 0 does not set it.
- R12: Writing the status byte with bit 1 = 0 clears the flag, and writing 1 there leaves it unchanged. A break event in low-power mode in the same cycle as a clear leaves the flag at 1.
- R13: `stop_exit` is 1 while a break is pending and `stop_mode` is 1, and 0 while either condition is false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | Qualifies `bus_addr` as a real bus cycle |
| bus_addr | input | 16 | CPU bus address |
| stop_mode | input | 1 | Core is in stop mode |
| wait_mode | input | 1 | Core is in wait mode |
| reg_we | input | 1 | Register write strobe |
| reg_off | input | 2 | Register offset: 0 control, 1 high byte, 2 low byte, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_off` (combinational) |
| brk_irq | output | 1 | Break interrupt request; high while the active flag is set |
| stop_exit | output | 1 | Wake request out of stop mode |

## Verification
The bench builds the unit with its default widths: a 16-bit address made of two 8-bit bytes, which gives a 2-bit offset with all four offsets in use. At this size the near-miss cases are in reach. Addresses that differ by one bit in the low byte or in the high byte exercise each per-byte comparator slice separately. The all-ones address checks the top bit of both slices. The priority corners are driven in single cycles: a hit together with an active-flag clear, and a low-power break together with a status clear.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

    // Break activity state
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } brk_state_e;

    // Bit position of the low-power break flag inside the status byte
    localparam int LP_BIT = 1;

    // Per-cycle events handed from decode/compare logic to the state machine
    typedef struct packed {
        logic hit;
        logic frc_set;
        logic act_clr;
        logic lp_clr;
    } brk_evt_t;

endpackage

// File: rtl/brkpt_regs.sv
module brkpt_regs
    import brkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int REG_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_off,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              act,
    input  logic              lp_flag,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              brk_en,
    output logic [ADDR_W-1:0] brk_addr,
    output logic              frc_set,
    output logic              act_clr,
    output logic              lp_clr
);

    localparam int NB      = ADDR_W / DATA_W;
    localparam int EN_BIT  = DATA_W - 1;
    localparam int ACT_BIT = DATA_W - 2;
    localparam logic [REG_AW-1:0] CTRL_OFF = '0;
    localparam logic [REG_AW-1:0] STAT_OFF = REG_AW'(NB + 1);

    logic ctrl_wr;
    logic stat_wr;

    assign ctrl_wr = reg_we && (reg_off == CTRL_OFF);
    assign stat_wr = reg_we && (reg_off == STAT_OFF);

    // Write-side event decode
    assign frc_set = ctrl_wr &&  reg_wdata[ACT_BIT];
    assign act_clr = ctrl_wr && !reg_wdata[ACT_BIT];
    assign lp_clr  = stat_wr && !reg_wdata[LP_BIT];

    // Enable flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_en <= 1'b0;
        end else if (ctrl_wr) begin
            brk_en <= reg_wdata[EN_BIT];
        end
    end

    // Address byte registers: offset 1 is the most significant byte
    for (genvar g = 0; g < NB; g++) begin : g_byte
        localparam logic [REG_AW-1:0] BYTE_OFF = REG_AW'(NB - g);
        logic [DATA_W-1:0] byte_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (reg_we && (reg_off == BYTE_OFF)) begin
                byte_q <= reg_wdata;
            end
        end

        assign brk_addr[g*DATA_W +: DATA_W] = byte_q;
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_off == CTRL_OFF) begin
            reg_rdata[EN_BIT]  = brk_en;
            reg_rdata[ACT_BIT] = act;
        end else if (reg_off == STAT_OFF) begin
            reg_rdata[LP_BIT] = lp_flag;
        end else begin
            for (int k = 0; k < NB; k++) begin
                if (reg_off == REG_AW'(k + 1)) begin
                    reg_rdata = brk_addr[(NB-1-k)*DATA_W +: DATA_W];
                end
            end
        end
    end

endmodule

// File: rtl/brkpt_match.sv
module brkpt_match #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              bus_vld,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              brk_en,
    input  logic [ADDR_W-1:0] brk_addr,
    output logic              hit
);

    localparam int NB = ADDR_W / DATA_W;

    logic [NB-1:0] byte_eq;

    // One equality slice per address byte
    for (genvar g = 0; g < NB; g++) begin : g_cmp
        assign byte_eq[g] = (bus_addr[g*DATA_W +: DATA_W] == brk_addr[g*DATA_W +: DATA_W]);
    end

    assign hit = bus_vld && brk_en && (&byte_eq);

endmodule

// File: rtl/brkpt_ctrl.sv
module brkpt_ctrl
    import brkpt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  brk_evt_t evt,
    input  logic     lp_mode,
    output logic     act,
    output logic     lp_flag
);

    brk_state_e state_q;
    brk_state_e state_d;
    logic       brk_event;

    assign brk_event = evt.hit || evt.frc_set;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a hit always wins over a software clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (brk_event) begin
                    state_d = ST_ACTIVE;          // T_HIT / T_FORCE
                end
            end
            ST_ACTIVE: begin
                if (evt.act_clr && !brk_event) begin
                    state_d = ST_IDLE;            // T_CLEAR
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        act = (state_q == ST_ACTIVE);
    end

    // Sticky low-power break flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_flag <= 1'b0;
        end else if (brk_event && lp_mode) begin
            lp_flag <= 1'b1;
        end else if (evt.lp_clr) begin
            lp_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit
    import brkpt_pkg::*;
#(
    parameter  int ADDR_W = 16,
    parameter  int DATA_W = 8,
    localparam int NB     = ADDR_W / DATA_W,
    localparam int REG_AW = $clog2(NB + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_vld,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              stop_mode,
    input  logic              wait_mode,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_off,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              brk_irq,
    output logic              stop_exit
);

    logic              brk_en;
    logic [ADDR_W-1:0] brk_addr;
    logic              lp_flag;
    logic              act;
    logic              hit;
    logic              frc_set;
    logic              act_clr;
    logic              lp_clr;
    brk_evt_t          evt;

    brkpt_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REG_AW (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .act       (act),
        .lp_flag   (lp_flag),
        .reg_rdata (reg_rdata),
        .brk_en    (brk_en),
        .brk_addr  (brk_addr),
        .frc_set   (frc_set),
        .act_clr   (act_clr),
        .lp_clr    (lp_clr)
    );

    brkpt_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_match (
        .bus_vld  (bus_vld),
        .bus_addr (bus_addr),
        .brk_en   (brk_en),
        .brk_addr (brk_addr),
        .hit      (hit)
    );

    assign evt = '{hit: hit, frc_set: frc_set, act_clr: act_clr, lp_clr: lp_clr};

    brkpt_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .lp_mode (stop_mode || wait_mode),
        .act     (act),
        .lp_flag (lp_flag)
    );

    assign brk_irq   = act;
    assign stop_exit = act && stop_mode;

endmodule

// File: rtl/brkpt_unit_chk.sv
module brkpt_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int REG_AW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_vld,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              stop_mode,
    input logic              wait_mode,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_off,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              brk_irq,
    input logic              stop_exit,
    input logic              brk_en,
    input logic [ADDR_W-1:0] brk_addr,
    input logic              lp_flag
);

    localparam logic [REG_AW-1:0] CTRL_OFF = '0;
    localparam logic [REG_AW-1:0] STAT_OFF = REG_AW'(ADDR_W / DATA_W + 1);

    logic c_hit, c_set_wr, c_clr_wr, c_lpclr_wr, c_lp;

    assign c_hit      = bus_vld && brk_en && (bus_addr == brk_addr);
    assign c_set_wr   = reg_we && (reg_off == CTRL_OFF) &&  reg_wdata[DATA_W-2];
    assign c_clr_wr   = reg_we && (reg_off == CTRL_OFF) && !reg_wdata[DATA_W-2];
    assign c_lpclr_wr = reg_we && (reg_off == STAT_OFF) && !reg_wdata[1];
    assign c_lp       = stop_mode || wait_mode;

    assert_ctrl_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_off == CTRL_OFF) |-> (reg_rdata[DATA_W-3:0] == '0));

    assert_hit_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_hit |=> brk_irq);

    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_en && !c_set_wr && !brk_irq) |=> !brk_irq);

    assert_no_vld_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_vld && !c_set_wr && !brk_irq) |=> !brk_irq);

    assert_force_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        c_set_wr |=> brk_irq);

    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_clr_wr && !c_hit) |=> !brk_irq);

    assert_hit_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_clr_wr && c_hit) |=> brk_irq);

    assert_lp_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_hit || c_set_wr) && c_lp) |=> lp_flag);

    assert_lp_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_flag && !c_lpclr_wr) |=> lp_flag);

    assert_lp_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (c_lpclr_wr && !((c_hit || c_set_wr) && c_lp)) |=> !lp_flag);

    assert_stop_wake_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(brk_irq) && stop_mode) |-> stop_exit);

    assert_stop_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_irq |-> !stop_exit);

endmodule

bind brkpt_unit brkpt_unit_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_AW (REG_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_vld   (bus_vld),
    .bus_addr  (bus_addr),
    .stop_mode (stop_mode),
    .wait_mode (wait_mode),
    .reg_we    (reg_we),
    .reg_off   (reg_off),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .brk_irq   (brk_irq),
    .stop_exit (stop_exit),
    .brk_en    (brk_en),
    .brk_addr  (brk_addr),
    .lp_flag   (lp_flag)
);

// File: tb/brkpt_unit_tb.sv
`timescale 1ns/1ps
module brkpt_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_vld = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        stop_mode = 1'b0;
    logic        wait_mode = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_off = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        brk_irq;
    logic        stop_exit;

    always #2 clk = ~clk;   // 250 MHz

    brkpt_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_vld   (bus_vld),
        .bus_addr  (bus_addr),
        .stop_mode (stop_mode),
        .wait_mode (wait_mode),
        .reg_we    (reg_we),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .brk_irq   (brk_irq),
        .stop_exit (stop_exit)
    );

    typedef struct {
        string      rq;
        logic [1:0] off;
        logic [7:0] rd;
        logic       irq;
        logic       ex;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state
    logic       m_en = 0, m_act = 0, m_lp = 0;
    logic [7:0] m_hi = 0, m_lo = 0;

    function automatic logic [7:0] exp_rd(input logic [1:0] off);
        case (off)
            2'd0:    return {m_en, m_act, 6'b0};
            2'd1:    return m_hi;
            2'd2:    return m_lo;
            default: return {6'b0, m_lp, 1'b0};
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive one cycle and update the model by the requirement rules
    task automatic cyc(input logic we, input logic [1:0] off, input logic [7:0] d,
                       input logic vld, input logic [15:0] a);
        logic hit, frc, clr, ev;
        hit = vld && m_en && (a == {m_hi, m_lo});
        frc = we && off == 2'd0 && d[6];
        clr = we && off == 2'd0 && !d[6];
        ev  = hit || frc;
        if (ev) m_act = 1'b1;
        else if (clr) m_act = 1'b0;
        if (ev && (stop_mode || wait_mode)) m_lp = 1'b1;
        else if (we && off == 2'd3 && !d[1]) m_lp = 1'b0;
        if (we && off == 2'd0) m_en = d[7];
        if (we && off == 2'd1) m_hi = d;
        if (we && off == 2'd2) m_lo = d;
        reg_we = we; reg_off = off; reg_wdata = d; bus_vld = vld; bus_addr = a;
        step();
        reg_we = 0; bus_vld = 0;
    endtask

    task automatic wr(input logic [1:0] off, input logic [7:0] d);
        cyc(1'b1, off, d, 1'b0, 16'h0);
    endtask

    task automatic bus(input logic vld, input logic [15:0] a);
        cyc(1'b0, 2'd0, 8'h00, vld, a);
    endtask

    // Push an expectation; the monitor compares it in this same cycle
    task automatic chk(input logic [1:0] off, input string rq);
        item_t it;
        reg_off = off;
        it.rq = rq; it.off = off; it.rd = exp_rd(off);
        it.irq = m_act; it.ex = m_act && stop_mode;
        q.push_back(it);
        step();
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if (reg_rdata !== it.rd || brk_irq !== it.irq || stop_exit !== it.ex) begin
                    bad++;
                    $display("FAIL %s off=%0d: rdata=%h irq=%b exit=%b expected rdata=%h irq=%b exit=%b",
                             it.rq, it.off, reg_rdata, brk_irq, stop_exit, it.rd, it.irq, it.ex);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        // R1 reset state
        chk(2'd0, "R1"); chk(2'd1, "R1"); chk(2'd2, "R1"); chk(2'd3, "R1");
        // R2 low control bits unimplemented
        wr(2'd0, 8'h3F); chk(2'd0, "R2");
        // R10 address bytes
        wr(2'd1, 8'h12); wr(2'd2, 8'h34);
        chk(2'd1, "R10"); chk(2'd2, "R10");
        // R4 disabled hit ignored
        bus(1'b1, 16'h1234); chk(2'd0, "R4");
        // R9 enable
        wr(2'd0, 8'h80); chk(2'd0, "R9");
        // R5 invalid cycle
        bus(1'b0, 16'h1234); chk(2'd0, "R5");
        // R3 near misses then hit
        bus(1'b1, 16'h1235); chk(2'd0, "R3");
        bus(1'b1, 16'h1334); chk(2'd0, "R3");
        bus(1'b1, 16'h1234); chk(2'd0, "R3");
        chk(2'd3, "R11");
        // R7 clear
        wr(2'd0, 8'h80); chk(2'd0, "R7");
        // R8 hit beats clear
        cyc(1'b1, 2'd0, 8'h80, 1'b1, 16'h1234); chk(2'd0, "R8");
        wr(2'd0, 8'h80); chk(2'd0, "R7");
        // R9 disarm
        wr(2'd0, 8'h00); chk(2'd0, "R9");
        bus(1'b1, 16'h1234); chk(2'd0, "R9");
        // R6 forced break without low power
        wr(2'd0, 8'h40); chk(2'd0, "R6"); chk(2'd3, "R11");
        wr(2'd0, 8'h00); chk(2'd0, "R7");
        // R11/R13 forced break in stop mode
        stop_mode = 1;
        chk(2'd0, "R13");
        wr(2'd0, 8'h40); chk(2'd3, "R11"); chk(2'd0, "R13");
        wr(2'd0, 8'h00); chk(2'd3, "R11"); chk(2'd0, "R13");
        // R12 write 1 no effect, write 0 clears
        wr(2'd3, 8'hFF); chk(2'd3, "R12");
        wr(2'd3, 8'h00); chk(2'd3, "R12");
        stop_mode = 0;
        // R11 hardware hit in wait mode, all-ones address
        wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd0, 8'h80);
        wait_mode = 1;
        bus(1'b1, 16'h7FFF); chk(2'd3, "R3");
        bus(1'b1, 16'hFFFE); chk(2'd0, "R3");
        bus(1'b1, 16'hFFFF); chk(2'd3, "R11"); chk(2'd0, "R13");
        wr(2'd0, 8'h80);
        // R12 set beats clear
        cyc(1'b1, 2'd3, 8'h00, 1'b1, 16'hFFFF); chk(2'd3, "R12");
        wait_mode = 0;
        wr(2'd0, 8'h80);
        wr(2'd3, 8'h00); chk(2'd3, "R12");
        // R11 hit outside low power leaves flag clear
        bus(1'b1, 16'hFFFF); chk(2'd3, "R11"); chk(2'd0, "R3");
        // R13 stop entered while pending
        stop_mode = 1; chk(2'd0, "R13");
        stop_mode = 0; chk(2'd0, "R13");
        repeat (2) step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule